// File: doc/BRIEF.md
# Address-Decoding Request Router with Access Mask

This block sits behind one master port of an interconnect and steers its read and write requests to one of four slave ports. Each slave owns a parameterized address window with an inclusive start and end. Each master port carries a parameterized permission mask that names the slaves it may reach, so the slaves it can see form a protected subset of the address map. A request whose address falls in no window, or whose chosen slave is not permitted, is taken by an internal error completer that always answers with a decode error.

Write requests fix a route that the following write data beats follow up to the last beat, and no new write address is taken while that burst is open. Read requests are steered per request. A separate combinational decoder maps the transaction ID of a returning completion to the master port it belongs to, using a per-master ID mask. Arbitration between masters and buffering belong to other blocks.

Top module: `req_router`

## Requirements
- R1: After reset, with all inputs idle, no slave valid, no error B valid and no error R valid is asserted.
- R2: A request whose address lies in slave s's range, both ends included, raises only bit s of the matching slave valid vector (`slv_aw_valid` or `slv_ar_valid`).
- R3: When the windows overlap, the lowest-numbered slave whose window holds the address is chosen.
- R4: When the chosen slave's bit in the permission mask is 0, no slave valid rises and the request goes to the error completer.
- R5: An address that lies in no window goes to the error completer.
- R6: `aw_ready` and `ar_ready` follow, in the same cycle, the ready of the selected slave or of the error completer.
- R7: After a write address handshake, write beats reach only the chosen target, and `w_ready` follows that target's ready, until the beat with `w_last`. While the burst is open, `aw_ready` and all `slv_aw_valid` bits stay 0.
- R8: For a refused write, the completer accepts and discards every beat up to `w_last`. It then raises `err_bvalid` with response 2'b11 (decode error) and the request's ID, and holds them until `err_bready`.
- R9: For a refused read of length field L, the completer returns L+1 beats with response 2'b11, the request's ID and zero data. `err_rlast` is high on the final beat only, and a beat is held while `err_rready` is low.
- R10: `cpl_sel` is one-hot for the lowest-numbered master m for which `cpl_id & MST_ID_MASK[m]` is nonzero. It is all zero when no master matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid from the master |
| aw_ready | output | 1 | Write address accepted |
| aw_addr | input | AW | Write address |
| aw_id | input | IDW | Write transaction ID |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| w_last | input | 1 | Final write beat |
| slv_aw_valid | output | NSLV | Write address valid per slave |
| slv_aw_ready | input | NSLV | Write address ready per slave |
| slv_w_valid | output | NSLV | Write beat valid per slave |
| slv_w_ready | input | NSLV | Write beat ready per slave |
| err_bvalid | output | 1 | Error write response valid |
| err_bready | input | 1 | Error write response taken |
| err_bid | output | IDW | Error write response ID |
| err_bresp | output | 2 | Error write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_addr | input | AW | Read address |
| ar_id | input | IDW | Read transaction ID |
| ar_len | input | 8 | Read beats minus one |
| slv_ar_valid | output | NSLV | Read address valid per slave |
| slv_ar_ready | input | NSLV | Read address ready per slave |
| err_rvalid | output | 1 | Error read beat valid |
| err_rready | input | 1 | Error read beat taken |
| err_rid | output | IDW | Error read beat ID |
| err_rresp | output | 2 | Error read beat response code |
| err_rdata | output | DW | Error read data, always zero |
| err_rlast | output | 1 | Final error read beat |
| cpl_id | input | IDW | ID of a returning completion |
| cpl_sel | output | NMST | One-hot master select for the completion |

## Verification
Routing, the ready paths and completion decoding are combinational. The bench drives inputs just after a falling edge and samples one time unit later in the same cycle. The write route is registered at the address handshake edge, so beat steering and the stall on `aw_ready` are checked in the cycle after that edge. The error write response appears in the first cycle after the edge that takes the last beat. The first error read beat appears in the cycle after the read address edge, and each later beat one cycle after the edge that takes the previous one. The bench samples each of these at the falling edge that follows the edge that causes it.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {
    EW_IDLE = 2'd0,
    EW_DATA = 2'd1,
    EW_RESP = 2'd2
  } ew_state_t;
endpackage

// File: rtl/rr_addr_dec.sv
module rr_addr_dec #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NSLV = 4,
  parameter logic [NSLV*AW-1:0] SLV_START = '0,
  parameter logic [NSLV*AW-1:0] SLV_END   = '0,
  parameter logic [NSLV-1:0]    ALLOW     = '1
) (
  input  logic [AW-1:0]   addr,
  output logic [NSLV-1:0] slv_sel,
  output logic            to_err
);
  logic [NSLV-1:0] in_win;
  logic [NSLV-1:0] first_win;

  for (genvar s = 0; s < NSLV; s++) begin : g_win
    assign in_win[s] = (addr >= SLV_START[s*AW +: AW]) &&
                       (addr <= SLV_END[s*AW +: AW]);
  end

  // lowest-numbered window wins, permission applied afterwards
  always_comb begin
    first_win = '0;
    for (int s = NSLV - 1; s >= 0; s--) begin
      if (in_win[s]) first_win = NSLV'(1) << s;
    end
  end

  assign slv_sel = first_win & ALLOW;
  assign to_err  = (slv_sel == '0);
endmodule

// File: rtl/rr_err_cpl.sv
module rr_err_cpl
  import rr_pkg::*;
#(
  parameter int unsigned IDW = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           aw_valid,
  output logic           aw_ready,
  input  logic [IDW-1:0] aw_id,
  input  logic           w_valid,
  output logic           w_ready,
  input  logic           w_last,
  output logic           b_valid,
  input  logic           b_ready,
  output logic [IDW-1:0] b_id,
  output logic [1:0]     b_resp,
  input  logic           ar_valid,
  output logic           ar_ready,
  input  logic [IDW-1:0] ar_id,
  input  logic [7:0]     ar_len,
  output logic           r_valid,
  input  logic           r_ready,
  output logic [IDW-1:0] r_id,
  output logic [1:0]     r_resp,
  output logic [DW-1:0]  r_data,
  output logic           r_last
);
  ew_state_t      ew_q, ew_d;
  logic [IDW-1:0] wid_q, wid_d;
  logic           rd_act_q, rd_act_d;
  logic [7:0]     rd_cnt_q, rd_cnt_d;
  logic [IDW-1:0] rid_q, rid_d;

  assign aw_ready = (ew_q == EW_IDLE);
  assign w_ready  = (ew_q == EW_DATA);
  assign b_valid  = (ew_q == EW_RESP);
  assign b_id     = wid_q;
  assign b_resp   = RESP_DECERR;

  always_comb begin
    ew_d  = ew_q;
    wid_d = wid_q;
    unique case (ew_q)
      EW_IDLE: if (aw_valid) begin
        ew_d  = EW_DATA;
        wid_d = aw_id;
      end
      EW_DATA: if (w_valid && w_last) ew_d = EW_RESP;
      EW_RESP: if (b_ready) ew_d = EW_IDLE;
      default: ew_d = EW_IDLE;
    endcase
  end

  assign ar_ready = !rd_act_q;
  assign r_valid  = rd_act_q;
  assign r_id     = rid_q;
  assign r_resp   = RESP_DECERR;
  assign r_data   = '0;
  assign r_last   = rd_act_q && (rd_cnt_q == 8'd0);

  always_comb begin
    rd_act_d = rd_act_q;
    rd_cnt_d = rd_cnt_q;
    rid_d    = rid_q;
    if (!rd_act_q && ar_valid) begin
      rd_act_d = 1'b1;
      rd_cnt_d = ar_len;
      rid_d    = ar_id;
    end else if (rd_act_q && r_ready) begin
      if (rd_cnt_q == 8'd0) rd_act_d = 1'b0;
      else                  rd_cnt_d = rd_cnt_q - 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ew_q     <= EW_IDLE;
      wid_q    <= '0;
      rd_act_q <= 1'b0;
      rd_cnt_q <= '0;
      rid_q    <= '0;
    end else begin
      ew_q     <= ew_d;
      wid_q    <= wid_d;
      rd_act_q <= rd_act_d;
      rd_cnt_q <= rd_cnt_d;
      rid_q    <= rid_d;
    end
  end
endmodule

// File: rtl/rr_cpl_dec.sv
module rr_cpl_dec #(
  parameter int unsigned IDW  = 4,
  parameter int unsigned NMST = 4,
  parameter logic [NMST*IDW-1:0] MST_ID_MASK = '0
) (
  input  logic [IDW-1:0]  cpl_id,
  output logic [NMST-1:0] cpl_sel
);
  logic [NMST-1:0] owns;

  for (genvar m = 0; m < NMST; m++) begin : g_own
    assign owns[m] = |(cpl_id & MST_ID_MASK[m*IDW +: IDW]);
  end

  always_comb begin
    cpl_sel = '0;
    for (int m = NMST - 1; m >= 0; m--) begin
      if (owns[m]) cpl_sel = NMST'(1) << m;
    end
  end
endmodule

// File: rtl/req_router.sv
module req_router #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned IDW  = 4,
  parameter int unsigned NSLV = 4,
  parameter int unsigned NMST = 4,
  parameter logic [NSLV*AW-1:0] SLV_START =
    {32'h0000_8000, 32'h0000_1800, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NSLV*AW-1:0] SLV_END =
    {32'h0000_8FFF, 32'h0000_2FFF, 32'h0000_1FFF, 32'h0000_0FFF},
  parameter logic [NSLV-1:0] ALLOW = 4'b0111,
  parameter logic [NMST*IDW-1:0] MST_ID_MASK = {4'b1000, 4'b0100, 4'b0010, 4'b0001}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            aw_valid,
  output logic            aw_ready,
  input  logic [AW-1:0]   aw_addr,
  input  logic [IDW-1:0]  aw_id,
  input  logic            w_valid,
  output logic            w_ready,
  input  logic            w_last,
  output logic [NSLV-1:0] slv_aw_valid,
  input  logic [NSLV-1:0] slv_aw_ready,
  output logic [NSLV-1:0] slv_w_valid,
  input  logic [NSLV-1:0] slv_w_ready,
  output logic            err_bvalid,
  input  logic            err_bready,
  output logic [IDW-1:0]  err_bid,
  output logic [1:0]      err_bresp,
  input  logic            ar_valid,
  output logic            ar_ready,
  input  logic [AW-1:0]   ar_addr,
  input  logic [IDW-1:0]  ar_id,
  input  logic [7:0]      ar_len,
  output logic [NSLV-1:0] slv_ar_valid,
  input  logic [NSLV-1:0] slv_ar_ready,
  output logic            err_rvalid,
  input  logic            err_rready,
  output logic [IDW-1:0]  err_rid,
  output logic [1:0]      err_rresp,
  output logic [DW-1:0]   err_rdata,
  output logic            err_rlast,
  input  logic [IDW-1:0]  cpl_id,
  output logic [NMST-1:0] cpl_sel
);
  logic [NSLV-1:0] aw_sel, ar_sel;
  logic            aw_err, ar_err;
  logic            e_aw_valid, e_aw_ready, e_w_valid, e_w_ready;
  logic            e_ar_valid, e_ar_ready;

  // write route register: busy flag plus target
  logic            wb_busy_q, wb_busy_d;
  logic [NSLV-1:0] wb_slv_q, wb_slv_d;
  logic            wb_err_q, wb_err_d;
  logic            aw_fire, w_end;

  rr_addr_dec #(.AW(AW), .NSLV(NSLV), .SLV_START(SLV_START),
                .SLV_END(SLV_END), .ALLOW(ALLOW)) u_aw_dec (
    .addr(aw_addr), .slv_sel(aw_sel), .to_err(aw_err));

  rr_addr_dec #(.AW(AW), .NSLV(NSLV), .SLV_START(SLV_START),
                .SLV_END(SLV_END), .ALLOW(ALLOW)) u_ar_dec (
    .addr(ar_addr), .slv_sel(ar_sel), .to_err(ar_err));

  // write address
  assign slv_aw_valid = (aw_valid && !wb_busy_q) ? aw_sel : '0;
  assign e_aw_valid   = aw_valid && !wb_busy_q && aw_err;
  assign aw_ready     = !wb_busy_q &&
                        (aw_err ? e_aw_ready : |(aw_sel & slv_aw_ready));
  assign aw_fire      = aw_valid && aw_ready;

  // write data follows the stored route
  assign slv_w_valid = (w_valid && wb_busy_q) ? wb_slv_q : '0;
  assign e_w_valid   = w_valid && wb_busy_q && wb_err_q;
  assign w_ready     = wb_busy_q &&
                       (wb_err_q ? e_w_ready : |(wb_slv_q & slv_w_ready));
  assign w_end       = w_valid && w_ready && w_last;

  always_comb begin
    wb_busy_d = wb_busy_q;
    wb_slv_d  = wb_slv_q;
    wb_err_d  = wb_err_q;
    if (aw_fire) begin
      wb_busy_d = 1'b1;
      wb_slv_d  = aw_sel;
      wb_err_d  = aw_err;
    end else if (w_end) begin
      wb_busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_busy_q <= 1'b0;
      wb_slv_q  <= '0;
      wb_err_q  <= 1'b0;
    end else begin
      wb_busy_q <= wb_busy_d;
      wb_slv_q  <= wb_slv_d;
      wb_err_q  <= wb_err_d;
    end
  end

  // read address
  assign slv_ar_valid = ar_valid ? ar_sel : '0;
  assign e_ar_valid   = ar_valid && ar_err;
  assign ar_ready     = ar_err ? e_ar_ready : |(ar_sel & slv_ar_ready);

  rr_err_cpl #(.IDW(IDW), .DW(DW)) u_err (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(e_aw_valid), .aw_ready(e_aw_ready), .aw_id(aw_id),
    .w_valid(e_w_valid), .w_ready(e_w_ready), .w_last(w_last),
    .b_valid(err_bvalid), .b_ready(err_bready), .b_id(err_bid), .b_resp(err_bresp),
    .ar_valid(e_ar_valid), .ar_ready(e_ar_ready), .ar_id(ar_id), .ar_len(ar_len),
    .r_valid(err_rvalid), .r_ready(err_rready), .r_id(err_rid),
    .r_resp(err_rresp), .r_data(err_rdata), .r_last(err_rlast));

  rr_cpl_dec #(.IDW(IDW), .NMST(NMST), .MST_ID_MASK(MST_ID_MASK)) u_cpl (
    .cpl_id(cpl_id), .cpl_sel(cpl_sel));
endmodule

// File: rtl/req_router_chk.sv
module req_router_chk #(
  parameter int unsigned IDW  = 4,
  parameter int unsigned NSLV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSLV-1:0] slv_aw_valid,
  input logic [NSLV-1:0] slv_ar_valid,
  input logic            err_bvalid,
  input logic            err_bready,
  input logic [IDW-1:0]  err_bid,
  input logic [1:0]      err_bresp,
  input logic            err_rvalid,
  input logic            err_rready,
  input logic [IDW-1:0]  err_rid,
  input logic [1:0]      err_rresp,
  input logic            err_rlast
);
  assert_aw_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_aw_valid));
  assert_ar_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slv_ar_valid));
  assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_bvalid && !err_bready |=> err_bvalid && $stable(err_bid));
  assert_b_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_bvalid |-> err_bresp == 2'b11);
  assert_r_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_rvalid && !err_rready |=> err_rvalid && $stable(err_rid) && $stable(err_rlast));
  assert_r_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_rvalid |-> err_rresp == 2'b11);
  assert_r_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_rvalid && err_rready && err_rlast |=> !err_rvalid);
endmodule

bind req_router req_router_chk #(.IDW(IDW), .NSLV(NSLV)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .slv_aw_valid(slv_aw_valid), .slv_ar_valid(slv_ar_valid),
  .err_bvalid(err_bvalid), .err_bready(err_bready), .err_bid(err_bid),
  .err_bresp(err_bresp), .err_rvalid(err_rvalid), .err_rready(err_rready),
  .err_rid(err_rid), .err_rresp(err_rresp), .err_rlast(err_rlast));

// File: tb/req_router_tb_top.sv
module req_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        aw_valid, aw_ready, w_valid, w_ready, w_last;
  logic [31:0] aw_addr, ar_addr;
  logic [3:0]  aw_id, ar_id, cpl_id, cpl_sel;
  logic [3:0]  slv_aw_valid, slv_aw_ready, slv_w_valid, slv_w_ready;
  logic [3:0]  slv_ar_valid, slv_ar_ready;
  logic        err_bvalid, err_bready, err_rvalid, err_rready, err_rlast;
  logic [3:0]  err_bid, err_rid;
  logic [1:0]  err_bresp, err_rresp;
  logic [31:0] err_rdata;
  logic        ar_valid, ar_ready;
  logic [7:0]  ar_len;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  req_router dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    aw_valid = 0; aw_addr = '0; aw_id = '0; w_valid = 0; w_last = 0;
    ar_valid = 0; ar_addr = '0; ar_id = '0; ar_len = '0;
    slv_aw_ready = '0; slv_w_ready = '0; slv_ar_ready = '0;
    err_bready = 0; err_rready = 0; cpl_id = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(slv_aw_valid == 0 && slv_ar_valid == 0 && slv_w_valid == 0, "R1 slave valids",
        {slv_aw_valid, slv_ar_valid, slv_w_valid}, 0);
    chk(!err_bvalid && !err_rvalid, "R1 error valids", {err_bvalid, err_rvalid}, 0);
  endtask

  task automatic ar_route(input logic [31:0] a, input logic [3:0] exp, input string req);
    @(negedge clk);
    ar_valid = 1; ar_addr = a; #1;
    chk(slv_ar_valid == exp, req, slv_ar_valid, exp);
    ar_valid = 0;
  endtask

  task automatic t_ranges();
    ar_route(32'h0000_0000, 4'b0001, "R2 slave0 start");
    ar_route(32'h0000_0FFF, 4'b0001, "R2 slave0 end");
    ar_route(32'h0000_1000, 4'b0010, "R2 slave1 start");
    ar_route(32'h0000_2FFF, 4'b0100, "R2 slave2 end");
    ar_route(32'h0000_1800, 4'b0010, "R3 overlap low slave wins");
    ar_route(32'h0000_1FFF, 4'b0010, "R3 overlap end");
    ar_route(32'h0000_2000, 4'b0100, "R3 past overlap");
    ar_route(32'h0000_8000, 4'b0000, "R4 forbidden slave3");
    ar_route(32'h0000_5000, 4'b0000, "R5 unmapped");
    ar_route(32'h0000_3000, 4'b0000, "R5 just past slave2");
  endtask

  task automatic t_ready();
    @(negedge clk);
    ar_valid = 1; ar_addr = 32'h0000_0010; slv_ar_ready = 4'b1110; #1;
    chk(ar_ready == 0, "R6 ar_ready low when slave0 not ready", ar_ready, 0);
    slv_ar_ready = 4'b0001; #1;
    chk(ar_ready == 1, "R6 ar_ready follows slave0", ar_ready, 1);
    aw_valid = 1; aw_addr = 32'h0000_2100; slv_aw_ready = 4'b1011; #1;
    chk(aw_ready == 0 && slv_aw_valid == 4'b0100, "R6 aw_ready low slave2 busy",
        {aw_ready, slv_aw_valid}, {1'b0, 4'b0100});
    ar_valid = 0; aw_valid = 0; slv_ar_ready = 0; slv_aw_ready = 0;
  endtask

  task automatic t_write_ok();
    @(negedge clk);
    aw_valid = 1; aw_addr = 32'h0000_1234; aw_id = 4'h2; slv_aw_ready = 4'b0010; #1;
    chk(aw_ready == 1, "R6 aw_ready from slave1", aw_ready, 1);
    @(negedge clk);
    aw_addr = 32'h0000_0004; slv_aw_ready = 4'b1111;
    w_valid = 1; w_last = 0; slv_w_ready = 4'b1101; #1;
    chk(aw_ready == 0 && slv_aw_valid == 0, "R7 aw stalled during burst",
        {aw_ready, slv_aw_valid}, 0);
    chk(slv_w_valid == 4'b0010 && w_ready == 0, "R7 beat to slave1, not ready",
        {slv_w_valid, w_ready}, {4'b0010, 1'b0});
    slv_w_ready = 4'b0010; #1;
    chk(w_ready == 1, "R7 w_ready follows slave1", w_ready, 1);
    @(negedge clk);
    w_last = 1; #1;
    chk(slv_w_valid == 4'b0010, "R7 last beat to slave1", slv_w_valid, 4'b0010);
    @(negedge clk);
    w_valid = 0; w_last = 0; #1;
    chk(aw_ready == 1 && slv_aw_valid == 4'b0001, "R7 new aw after last",
        {aw_ready, slv_aw_valid}, {1'b1, 4'b0001});
    aw_valid = 0; slv_aw_ready = 0; slv_w_ready = 0;
  endtask

  task automatic t_write_err();
    @(negedge clk);
    aw_valid = 1; aw_addr = 32'h0000_8010; aw_id = 4'h5; slv_aw_ready = 4'b1111; #1;
    chk(aw_ready == 1 && slv_aw_valid == 0, "R4 forbidden aw to completer",
        {aw_ready, slv_aw_valid}, {1'b1, 4'b0});
    @(negedge clk);
    aw_valid = 0; w_valid = 1; w_last = 0; slv_w_ready = 4'b1111; #1;
    chk(w_ready == 1 && slv_w_valid == 0, "R8 beat discarded",
        {w_ready, slv_w_valid}, {1'b1, 4'b0});
    chk(!err_bvalid, "R8 no B before last", err_bvalid, 0);
    @(negedge clk);
    w_last = 1; #1;
    chk(!err_bvalid, "R8 no B on last beat cycle", err_bvalid, 0);
    @(negedge clk);
    w_valid = 0; w_last = 0; #1;
    chk(err_bvalid && err_bresp == 2'b11 && err_bid == 4'h5, "R8 B decerr",
        {err_bvalid, err_bresp, err_bid}, {1'b1, 2'b11, 4'h5});
    @(negedge clk); #1;
    chk(err_bvalid && err_bid == 4'h5, "R8 B held", {err_bvalid, err_bid}, {1'b1, 4'h5});
    err_bready = 1;
    @(negedge clk);
    err_bready = 0; #1;
    chk(!err_bvalid, "R8 B dropped after bready", err_bvalid, 0);
    slv_aw_ready = 0; slv_w_ready = 0;
  endtask

  task automatic t_read_err();
    @(negedge clk);
    ar_valid = 1; ar_addr = 32'h0000_5000; ar_id = 4'h9; ar_len = 8'd2;
    slv_ar_ready = 4'b1111; #1;
    chk(ar_ready == 1 && slv_ar_valid == 0, "R5 unmapped ar to completer",
        {ar_ready, slv_ar_valid}, {1'b1, 4'b0});
    @(negedge clk);
    ar_valid = 0; #1;
    chk(err_rvalid && !err_rlast && err_rid == 4'h9 && err_rresp == 2'b11 && err_rdata == 0,
        "R9 beat 1", {err_rvalid, err_rlast, err_rid, err_rresp}, {1'b1, 1'b0, 4'h9, 2'b11});
    @(negedge clk); #1;
    chk(err_rvalid && !err_rlast, "R9 beat 1 held", {err_rvalid, err_rlast}, 2'b10);
    err_rready = 1;
    @(negedge clk); #1;
    chk(err_rvalid && !err_rlast, "R9 beat 2", {err_rvalid, err_rlast}, 2'b10);
    @(negedge clk); #1;
    chk(err_rvalid && err_rlast, "R9 beat 3 last", {err_rvalid, err_rlast}, 2'b11);
    @(negedge clk); #1;
    chk(!err_rvalid, "R9 burst over", err_rvalid, 0);
    err_rready = 0; slv_ar_ready = 0;
  endtask

  task automatic t_read_single();
    @(negedge clk);
    ar_valid = 1; ar_addr = 32'h0000_8FFF; ar_id = 4'h3; ar_len = 8'd0; err_rready = 1; #1;
    chk(ar_ready == 1, "R4 forbidden ar taken by completer", ar_ready, 1);
    @(negedge clk);
    ar_valid = 0; #1;
    chk(err_rvalid && err_rlast && err_rid == 4'h3, "R9 single beat last",
        {err_rvalid, err_rlast, err_rid}, {1'b1, 1'b1, 4'h3});
    @(negedge clk); #1;
    chk(!err_rvalid, "R9 single beat done", err_rvalid, 0);
    err_rready = 0;
  endtask

  task automatic t_cpl();
    logic [3:0] ids [5] = '{4'h1, 4'h6, 4'h4, 4'h8, 4'h0};
    logic [3:0] exp [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0000};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cpl_id = ids[i]; #1;
      chk(cpl_sel == exp[i], "R10 completion select", cpl_sel, exp[i]);
    end
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ranges();
    t_ready();
    t_write_ok();
    t_write_err();
    t_read_err();
    t_read_single();
    t_cpl();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule